// File: doc/BRIEF.md
# Eight-Line GPIO Bank with Pad Multiplexing

This block is a bank of general-purpose I/O lines that software controls through a small register bus. Each line can be an input or an output. As an output it can push-pull or open-drain, and its level can be written directly or changed atomically through write-only set and clear strobes. As an input it passes through a two-stage synchronizer and an optional debouncer. The filtered level feeds edge detectors that latch sticky status bits, and those bits drive a maskable interrupt and a wake-up request.

A per-line select hands the pad to a secondary function. When a line is selected this way, its output enable, output value and pull controls come straight from that function's own signals, and the GPIO registers no longer touch the line. A global enable bit tri-states every primary line and stops edge capture without losing any register contents.

Register writes take effect at the next clock edge. Reads are combinational from the address.

Top module: `gpio_bank`

## Requirements
- R13: After reset every register reads 0, so all lines are inputs and disabled, `pad_oe` is 0, and `irq` and `wake` are low.
- R1: The direction register at address 0 holds one bit per line, with 1 meaning output. It reads back what was written. A primary line drives `pad_oe` only when its direction bit is 1 and the global enable is on.
- R2: The output data register at address 2 is read/write. A push-pull output line puts its bit on `pad_out`.
- R3: Writing address 3 sets every output data bit whose written bit is 1. Writing address 4 clears every output data bit whose written bit is 1. Bits written 0 stay unchanged, and both addresses read as 0.
- R4: When a line's bit in the open-drain register at address 9 is 1, the line asserts `pad_oe` only while its data bit is 0. It never drives `pad_out` high.
- R5: Pull-up enables at address 7 and pull-down enables at address 8 reach `pad_pu` and `pad_pd`. If both are set on a line, only the pull-up is applied.
- R6: Bit 0 of the control register at address 6 is the global enable. While it is 0, every primary line has `pad_oe` at 0 and no status bit is set, but all other registers keep their values.
- R7: The input register at address 1 shows each pad level after a two-flop synchronizer. With debounce off, a pad change shows in the third clock edge after it occurs, and not earlier.
- R8: A line whose bit is set in the debounce register at address 5 accepts a new level only after the synchronized level has differed from the accepted level for DEB_TICKS consecutive sample ticks (4 by default, with one tick per clock). A shorter pulse is ignored.
- R9: A line whose bit is set in the select register at address 15 takes `pad_oe`, `pad_out`, `pad_pu` and `pad_pd` from `alt_oe`, `alt_out`, `alt_pu` and `alt_pd`. This holds regardless of direction, data, pull or global enable settings, and the line sets no status bit.
- R10: The rising-edge enables at address 10 and falling-edge enables at address 11 let a line latch a sticky status bit on either edge or on both edges. The status register at address 13 clears a bit only when 1 is written to it.
- R11: A line whose bit is 1 in the mask register at address 12 still sets its status bit but does not raise `irq`. `irq` is high whenever some unmasked status bit is set.
- R12: `wake` is high whenever a set status bit has its bit set in the wake-enable register at address 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | NLINES | Write data |
| bus_rdata | output | NLINES | Read data for `bus_addr` |
| pad_in | input | NLINES | Pad input levels |
| pad_oe | output | NLINES | Pad output enable |
| pad_out | output | NLINES | Pad output value |
| pad_pu | output | NLINES | Pad pull-up enable |
| pad_pd | output | NLINES | Pad pull-down enable |
| alt_oe | input | NLINES | Secondary function output enable |
| alt_out | input | NLINES | Secondary function output value |
| alt_pu | input | NLINES | Secondary function pull-up |
| alt_pd | input | NLINES | Secondary function pull-down |
| irq | output | 1 | Interrupt request from unmasked status |
| wake | output | 1 | Wake-up request from wake-enabled status |

## Verification
A corrupted configuration register is visible on the pad controls right after the write that sets it, because the pad outputs are combinational from register state. A wrong synchronizer or debounce count moves the cycle in which the input register changes, and the bench samples on both sides of that cycle. A status bit that is not sticky, or that is captured while disabled or while the line is selected for its secondary function, shows at the status readback and on `irq` or `wake` within a few cycles of the pad edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      REG_DIR  = 4'd0,
      REG_DIN  = 4'd1,
      REG_DOUT = 4'd2,
      REG_SET  = 4'd3,
      REG_CLR  = 4'd4,
      REG_DEB  = 4'd5,
      REG_CTRL = 4'd6,
      REG_PU   = 4'd7,
      REG_PD   = 4'd8,
      REG_OD   = 4'd9,
      REG_RISE = 4'd10,
      REG_FALL = 4'd11,
      REG_MASK = 4'd12,
      REG_STAT = 4'd13,
      REG_WAKE = 4'd14,
      REG_FSEL = 4'd15
   } reg_addr_e;

endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int NLINES = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [NLINES-1:0]   bus_wdata,
   output logic [NLINES-1:0]   bus_rdata,
   input  logic [NLINES-1:0]   din,
   input  logic [NLINES-1:0]   stat,
   output logic [NLINES-1:0]   dir,
   output logic [NLINES-1:0]   dout,
   output logic [NLINES-1:0]   deb_en,
   output logic                gen,
   output logic [NLINES-1:0]   pu,
   output logic [NLINES-1:0]   pd,
   output logic [NLINES-1:0]   od,
   output logic [NLINES-1:0]   rise_en,
   output logic [NLINES-1:0]   fall_en,
   output logic [NLINES-1:0]   mask,
   output logic [NLINES-1:0]   wake_en,
   output logic [NLINES-1:0]   fsel,
   output logic [NLINES-1:0]   stat_clr
);

   logic [NLINES-1:0] dir_q, dout_q, deb_q, pu_q, pd_q, od_q;
   logic [NLINES-1:0] rise_q, fall_q, mask_q, wake_q, fsel_q;
   logic              gen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         dout_q <= '0;
         deb_q  <= '0;
         pu_q   <= '0;
         pd_q   <= '0;
         od_q   <= '0;
         rise_q <= '0;
         fall_q <= '0;
         mask_q <= '0;
         wake_q <= '0;
         fsel_q <= '0;
         gen_q  <= 1'b0;
      end else if (bus_wr) begin
         case (bus_addr)
            REG_DIR:  dir_q  <= bus_wdata;
            REG_DOUT: dout_q <= bus_wdata;
            REG_SET:  dout_q <= dout_q | bus_wdata;
            REG_CLR:  dout_q <= dout_q & ~bus_wdata;
            REG_DEB:  deb_q  <= bus_wdata;
            REG_CTRL: gen_q  <= bus_wdata[0];
            REG_PU:   pu_q   <= bus_wdata;
            REG_PD:   pd_q   <= bus_wdata;
            REG_OD:   od_q   <= bus_wdata;
            REG_RISE: rise_q <= bus_wdata;
            REG_FALL: fall_q <= bus_wdata;
            REG_MASK: mask_q <= bus_wdata;
            REG_WAKE: wake_q <= bus_wdata;
            REG_FSEL: fsel_q <= bus_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         REG_DIR:  bus_rdata = dir_q;
         REG_DIN:  bus_rdata = din;
         REG_DOUT: bus_rdata = dout_q;
         REG_DEB:  bus_rdata = deb_q;
         REG_CTRL: bus_rdata[0] = gen_q;
         REG_PU:   bus_rdata = pu_q;
         REG_PD:   bus_rdata = pd_q;
         REG_OD:   bus_rdata = od_q;
         REG_RISE: bus_rdata = rise_q;
         REG_FALL: bus_rdata = fall_q;
         REG_MASK: bus_rdata = mask_q;
         REG_STAT: bus_rdata = stat;
         REG_WAKE: bus_rdata = wake_q;
         REG_FSEL: bus_rdata = fsel_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign stat_clr = (bus_wr && bus_addr == REG_STAT) ? bus_wdata : '0;

   assign dir     = dir_q;
   assign dout    = dout_q;
   assign deb_en  = deb_q;
   assign gen     = gen_q;
   assign pu      = pu_q;
   assign pd      = pd_q;
   assign od      = od_q;
   assign rise_en = rise_q;
   assign fall_en = fall_q;
   assign mask    = mask_q;
   assign wake_en = wake_q;
   assign fsel    = fsel_q;

   // R3: set strobe leaves every written-1 bit high
   assert_set_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_SET) |=> ((dout_q & $past(bus_wdata)) == $past(bus_wdata)));

   // R3: clear strobe leaves every written-1 bit low
   assert_clr_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_CLR) |=> ((dout_q & $past(bus_wdata)) == '0));

   // R3: an all-zero strobe changes nothing
   assert_zero_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (bus_addr == REG_SET || bus_addr == REG_CLR) && bus_wdata == '0)
      |=> $stable(dout_q));

endmodule

// File: rtl/gpio_bank_infilt.sv
module gpio_bank_infilt #(
   parameter int NLINES    = 8,
   parameter int DEB_TICKS = 4,
   parameter int TICK_DIV  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] pad_in,
   input  logic [NLINES-1:0] deb_en,
   output logic [NLINES-1:0] filt
);

   localparam int CW = $clog2(DEB_TICKS);
   localparam logic [CW-1:0] CNT_LAST = CW'(DEB_TICKS - 1);
   localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   if (DEB_TICKS < 2) begin : g_bad_deb
      $error("gpio_bank_infilt: DEB_TICKS must be at least 2");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("gpio_bank_infilt: TICK_DIV must be at least 1");
   end

   logic tick;

   if (TICK_DIV == 1) begin : g_tick_every
      assign tick = 1'b1;
   end else begin : g_tick_div
      localparam logic [TW-1:0] DIV_LAST = TW'(TICK_DIV - 1);
      logic [TW-1:0] tcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              tcnt <= '0;
         else if (tcnt == DIV_LAST) tcnt <= '0;
         else                     tcnt <= tcnt + 1'b1;
      end
      assign tick = (tcnt == DIV_LAST);
   end

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      logic          s0, s1, acc;
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s0  <= 1'b0;
            s1  <= 1'b0;
            acc <= 1'b0;
            cnt <= '0;
         end else begin
            s0 <= pad_in[i];
            s1 <= s0;
            if (!deb_en[i]) begin
               acc <= s1;
               cnt <= '0;
            end else if (s1 == acc) begin
               cnt <= '0;
            end else if (tick) begin
               if (cnt == CNT_LAST) begin
                  acc <= s1;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end

      assign filt[i] = acc;

      // R8: with debounce on, the accepted level moves only at the end of a full run
      assert_deb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (deb_en[i] && !(tick && cnt == CNT_LAST)) |=> $stable(acc));

      // R8: an accepted change always matches the synchronized level
      assert_deb_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (deb_en[i] && acc != s1 && tick && cnt == CNT_LAST) |=> (acc == $past(s1)));
   end

endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
   parameter int NLINES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] filt,
   input  logic              gen,
   input  logic [NLINES-1:0] fsel,
   input  logic [NLINES-1:0] rise_en,
   input  logic [NLINES-1:0] fall_en,
   input  logic [NLINES-1:0] mask,
   input  logic [NLINES-1:0] wake_en,
   input  logic [NLINES-1:0] stat_clr,
   output logic [NLINES-1:0] stat,
   output logic              irq,
   output logic              wake
);

   logic [NLINES-1:0] prev_q, stat_q, ev;

   always_comb begin
      ev = ((filt & ~prev_q & rise_en) | (~filt & prev_q & fall_en)) & ~fsel;
      if (!gen) ev = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         stat_q <= '0;
      end else begin
         prev_q <= filt;
         stat_q <= (stat_q & ~stat_clr) | ev;
      end
   end

   assign stat = stat_q;
   assign irq  = |(stat_q & ~mask);
   assign wake = |(stat_q & wake_en);

   // R10: a status bit falls only when 1 was written to it
   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(stat_q) & ~$past(stat_clr) & ~stat_q) == '0));

   // R6: no status bit rises while the bank is disabled
   assert_no_capture_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !gen |=> ((stat_q & ~$past(stat_q)) == '0));

   // R9: a line handed to its secondary function never gains a status bit
   assert_no_capture_alt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & ~$past(stat_q) & $past(fsel)) == '0));

endmodule

// File: rtl/gpio_bank_padmux.sv
module gpio_bank_padmux #(
   parameter int NLINES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gen,
   input  logic [NLINES-1:0] fsel,
   input  logic [NLINES-1:0] dir,
   input  logic [NLINES-1:0] dout,
   input  logic [NLINES-1:0] od,
   input  logic [NLINES-1:0] pu,
   input  logic [NLINES-1:0] pd,
   input  logic [NLINES-1:0] alt_oe,
   input  logic [NLINES-1:0] alt_out,
   input  logic [NLINES-1:0] alt_pu,
   input  logic [NLINES-1:0] alt_pd,
   output logic [NLINES-1:0] pad_oe,
   output logic [NLINES-1:0] pad_out,
   output logic [NLINES-1:0] pad_pu,
   output logic [NLINES-1:0] pad_pd
);

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      logic drive, p_oe, p_out;

      assign drive = gen & dir[i];
      assign p_oe  = drive & (~od[i] | ~dout[i]);
      assign p_out = drive & ~od[i] & dout[i];

      always_comb begin
         if (fsel[i]) begin
            pad_oe[i]  = alt_oe[i];
            pad_out[i] = alt_out[i];
            pad_pu[i]  = alt_pu[i];
            pad_pd[i]  = alt_pd[i];
         end else begin
            pad_oe[i]  = p_oe;
            pad_out[i] = p_out;
            pad_pu[i]  = pu[i];
            pad_pd[i]  = pd[i] & ~pu[i];
         end
      end

      // R4: an open-drain primary line never actively drives high
      assert_od_no_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!fsel[i] && od[i]) |-> !(pad_oe[i] && pad_out[i]));

      // R5: the two pulls on a primary line are never on together
      assert_pull_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !fsel[i] |-> !(pad_pu[i] && pad_pd[i]));
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int NLINES    = 8,
   parameter int DEB_TICKS = 4,
   parameter int TICK_DIV  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [3:0]        bus_addr,
   input  logic [NLINES-1:0] bus_wdata,
   output logic [NLINES-1:0] bus_rdata,
   input  logic [NLINES-1:0] pad_in,
   output logic [NLINES-1:0] pad_oe,
   output logic [NLINES-1:0] pad_out,
   output logic [NLINES-1:0] pad_pu,
   output logic [NLINES-1:0] pad_pd,
   input  logic [NLINES-1:0] alt_oe,
   input  logic [NLINES-1:0] alt_out,
   input  logic [NLINES-1:0] alt_pu,
   input  logic [NLINES-1:0] alt_pd,
   output logic              irq,
   output logic              wake
);

   if (NLINES < 1 || NLINES > 32) begin : g_bad_lines
      $error("gpio_bank: NLINES must be between 1 and 32");
   end

   logic [NLINES-1:0] dir, dout, deb_en, pu, pd, od;
   logic [NLINES-1:0] rise_en, fall_en, mask, wake_en, fsel;
   logic [NLINES-1:0] stat_clr, stat, filt;
   logic              gen;

   gpio_bank_regs #(.NLINES(NLINES)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .din      (filt),
      .stat     (stat),
      .dir      (dir),
      .dout     (dout),
      .deb_en   (deb_en),
      .gen      (gen),
      .pu       (pu),
      .pd       (pd),
      .od       (od),
      .rise_en  (rise_en),
      .fall_en  (fall_en),
      .mask     (mask),
      .wake_en  (wake_en),
      .fsel     (fsel),
      .stat_clr (stat_clr)
   );

   gpio_bank_infilt #(
      .NLINES   (NLINES),
      .DEB_TICKS(DEB_TICKS),
      .TICK_DIV (TICK_DIV)
   ) u_infilt (
      .clk   (clk),
      .rst_n (rst_n),
      .pad_in(pad_in),
      .deb_en(deb_en),
      .filt  (filt)
   );

   gpio_bank_edge #(.NLINES(NLINES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .filt    (filt),
      .gen     (gen),
      .fsel    (fsel),
      .rise_en (rise_en),
      .fall_en (fall_en),
      .mask    (mask),
      .wake_en (wake_en),
      .stat_clr(stat_clr),
      .stat    (stat),
      .irq     (irq),
      .wake    (wake)
   );

   gpio_bank_padmux #(.NLINES(NLINES)) u_padmux (
      .clk    (clk),
      .rst_n  (rst_n),
      .gen    (gen),
      .fsel   (fsel),
      .dir    (dir),
      .dout   (dout),
      .od     (od),
      .pu     (pu),
      .pd     (pd),
      .alt_oe (alt_oe),
      .alt_out(alt_out),
      .alt_pu (alt_pu),
      .alt_pd (alt_pd),
      .pad_oe (pad_oe),
      .pad_out(pad_out),
      .pad_pu (pad_pu),
      .pad_pd (pad_pd)
   );

   // R6: with the bank disabled only secondary lines may drive
   assert_off_tristate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !gen |-> ((pad_oe & ~fsel) == '0));

   // R11: irq never rises without a fresh or standing unmasked status bit
   assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ((u_edge.stat & ~mask) != '0));

endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_wr = 1'b0;
   logic [3:0]   bus_addr = '0;
   logic [N-1:0] bus_wdata = '0;
   logic [N-1:0] bus_rdata;
   logic [N-1:0] pad_in = '0;
   logic [N-1:0] pad_oe, pad_out, pad_pu, pad_pd;
   logic [N-1:0] alt_oe = 8'hFF;
   logic [N-1:0] alt_out = 8'h55;
   logic [N-1:0] alt_pu = 8'h00;
   logic [N-1:0] alt_pd = 8'hFF;
   logic         irq, wake;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   gpio_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
      .alt_oe(alt_oe), .alt_out(alt_out), .alt_pu(alt_pu), .alt_pd(alt_pd),
      .irq(irq), .wake(wake)
   );

   typedef struct packed {
      logic [3:0] wa;
      logic [7:0] wd;
      logic [3:0] ra;
      logic [7:0] re;
      logic [7:0] oe;
      logic [7:0] out;
      logic [7:0] req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{4'd6,  8'h01, 4'd6,  8'h01, 8'h00, 8'h00, 8'd6},  // R6 enable on, nothing driven yet
      '{4'd0,  8'h0F, 4'd0,  8'h0F, 8'h0F, 8'h00, 8'd1},  // R1 low four lines output
      '{4'd2,  8'h05, 4'd2,  8'h05, 8'h0F, 8'h05, 8'd2},  // R2 data write
      '{4'd3,  8'h0A, 4'd2,  8'h0F, 8'h0F, 8'h0F, 8'd3},  // R3 set strobe
      '{4'd4,  8'h03, 4'd2,  8'h0C, 8'h0F, 8'h0C, 8'd3},  // R3 clear strobe
      '{4'd3,  8'h00, 4'd2,  8'h0C, 8'h0F, 8'h0C, 8'd3},  // R3 zero set
      '{4'd4,  8'h00, 4'd2,  8'h0C, 8'h0F, 8'h0C, 8'd3},  // R3 zero clear
      '{4'd9,  8'h0C, 4'd9,  8'h0C, 8'h03, 8'h00, 8'd4},  // R4 open-drain high released
      '{4'd4,  8'h04, 4'd2,  8'h08, 8'h07, 8'h00, 8'd4},  // R4 open-drain low driven
      '{4'd6,  8'h00, 4'd6,  8'h00, 8'h00, 8'h00, 8'd6},  // R6 disable tri-states
      '{4'd6,  8'h01, 4'd3,  8'h00, 8'h07, 8'h00, 8'd6},  // R6 re-enable, R3 set reads 0
      '{4'd15, 8'h01, 4'd15, 8'h01, 8'h07, 8'h01, 8'd9},  // R9 line0 to secondary
      '{4'd6,  8'h00, 4'd6,  8'h00, 8'h01, 8'h01, 8'd9},  // R9 secondary ignores disable
      '{4'd0,  8'h00, 4'd0,  8'h00, 8'h01, 8'h01, 8'd9},  // R9 secondary ignores direction
      '{4'd6,  8'h01, 4'd4,  8'h00, 8'h01, 8'h01, 8'd9},  // R9 still secondary
      '{4'd15, 8'h00, 4'd15, 8'h00, 8'h00, 8'h00, 8'd1}   // R1 all inputs now
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic wait_n(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #400000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // R13 reset state
      rd(4'd0, r);  chk("R13", "dir reset", r, 8'h00);
      rd(4'd2, r);  chk("R13", "dout reset", r, 8'h00);
      rd(4'd6, r);  chk("R13", "ctrl reset", r, 8'h00);
      chk("R13", "pad_oe reset", pad_oe, 8'h00);
      chk("R13", "irq/wake reset", {irq, wake}, 2'b00);

      for (int v = 0; v < NV; v++) begin
         wr(VECS[v].wa, VECS[v].wd);
         rd(VECS[v].ra, r);
         chk($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d readback", v), r, VECS[v].re);
         chk($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d pad_oe", v), pad_oe, VECS[v].oe);
         chk($sformatf("R%0d", VECS[v].req), $sformatf("vec %0d pad_out", v), pad_out, VECS[v].out);
      end

      // R5 pulls and conflict
      wr(4'd7, 8'hF0);
      wr(4'd8, 8'h3C);
      #0.5;
      chk("R5", "pad_pu", pad_pu, 8'hF0);
      chk("R5", "pad_pd pull-up wins", pad_pd, 8'h0C);
      wr(4'd15, 8'h10);
      #0.5;
      chk("R9", "secondary pull-up", pad_pu, 8'hE0);
      chk("R9", "secondary pull-down", pad_pd, 8'h1C);
      wr(4'd15, 8'h00);
      wr(4'd7, 8'h00);
      wr(4'd8, 8'h00);

      // R7 synchronizer latency, bank enabled, all inputs
      wr(4'd10, 8'h01);
      wr(4'd11, 8'h80);
      @(negedge clk);
      pad_in = 8'h81;
      wait_n(2);
      rd(4'd1, r); chk("R7", "din before third edge", r, 8'h00);
      wait_n(1);
      rd(4'd1, r); chk("R7", "din at third edge", r, 8'h81);
      wait_n(3);
      // R10 rising on line0 only
      rd(4'd13, r); chk("R10", "rise status", r, 8'h01);
      chk("R11", "irq unmasked", irq, 1'b1);
      pad_in = 8'h01;
      wait_n(5);
      rd(4'd13, r); chk("R10", "fall status", r, 8'h81);
      wr(4'd13, 8'h00);
      rd(4'd13, r); chk("R10", "write 0 keeps status", r, 8'h81);
      wr(4'd13, 8'h01);
      rd(4'd13, r); chk("R10", "write 1 clears bit", r, 8'h80);
      wr(4'd12, 8'h80);
      #0.5;
      chk("R11", "irq masked", irq, 1'b0);
      rd(4'd13, r); chk("R11", "masked status kept", r, 8'h80);
      chk("R12", "wake off", wake, 1'b0);
      wr(4'd14, 8'h80);
      #0.5;
      chk("R12", "wake on", wake, 1'b1);
      wr(4'd13, 8'h80);
      #0.5;
      chk("R12", "wake cleared", wake, 1'b0);
      wr(4'd12, 8'h00);

      // R10 both edges on line1
      wr(4'd10, 8'h02);
      wr(4'd11, 8'h02);
      pad_in = 8'h03;
      wait_n(5);
      rd(4'd13, r); chk("R10", "both: rise", r, 8'h02);
      wr(4'd13, 8'hFF);
      pad_in = 8'h01;
      wait_n(5);
      rd(4'd13, r); chk("R10", "both: fall", r, 8'h02);
      wr(4'd13, 8'hFF);

      // R6 no capture while disabled
      wr(4'd11, 8'hFF);
      wr(4'd6, 8'h00);
      pad_in = 8'h00;
      wait_n(5);
      rd(4'd13, r); chk("R6", "no status when off", r, 8'h00);
      rd(4'd1, r);  chk("R6", "din still sampled", r, 8'h00);
      wr(4'd6, 8'h01);
      wait_n(2);
      rd(4'd13, r); chk("R6", "no spurious edge on enable", r, 8'h00);

      // R9 no capture for secondary line
      wr(4'd15, 8'h04);
      wr(4'd10, 8'h04);
      pad_in = 8'h04;
      wait_n(5);
      rd(4'd13, r); chk("R9", "secondary no status", r, 8'h00);
      chk("R9", "irq quiet", irq, 1'b0);
      wr(4'd15, 8'h00);
      wr(4'd10, 8'h00);
      wr(4'd11, 8'h00);
      pad_in = 8'h00;
      wait_n(5);
      wr(4'd13, 8'hFF);

      // R8 debounce on line3
      wr(4'd5, 8'h08);
      pad_in = 8'h08;
      wait_n(3);
      pad_in = 8'h00;
      wait_n(10);
      rd(4'd1, r); chk("R8", "short pulse ignored", r, 8'h00);
      pad_in = 8'h08;
      wait_n(5);
      rd(4'd1, r); chk("R8", "not yet accepted", r, 8'h00);
      wait_n(1);
      rd(4'd1, r); chk("R8", "accepted after run", r, 8'h08);

      finish_run();
   end

endmodule